// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives characters from the single shared data line of a smart card link. A falling edge on the idle-high line announces a character. The block confirms it half a bit later, then samples eight data bits and one parity bit at the middle of each bit cell. One bit cell lasts `bit_cycles` clock cycles, a run-time input. A character with good parity goes into a one-entry receive register. A character with bad parity is still written into that register, but it is not offered to the consumer. The block then pulls the line low for one bit time, which tells the sender to repeat the character.

The received byte leaves through a valid/ready stream port. `rx_valid` is the receive-ready flag. A cycle with `rx_valid` and `rx_ready` both high is the read strobe, and it clears the flag. Back-pressure is supported. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value, with one exception: a character with bad parity overwrites `rx_data` even while the flag is set. If a good character completes while the consumer is still applying back-pressure, the old byte is kept and the overrun flag is raised. The parity-error flag and the overrun flag are sticky. Each is cleared by a pulse on its own clear pin. A receive interrupt and an error interrupt are both gated by a single enable.

Top module: `sc_rx_top`

## Requirements
- R1: Frame format. A character is a low start bit, then eight data bits sent least significant bit first, then a parity bit. Parity is even: the XOR of the eight data bits and the parity bit is 0. Each bit is sampled once, near the middle of its cell, and a cell lasts `bit_cycles` clocks (`bit_cycles` >= 4).
- R2: A low pulse on the idle line that has ended by the middle of the start bit is discarded. It changes no output, and a proper character that follows is received correctly.
- R3: A character with good parity is loaded into `rx_data` and sets `rx_valid`, provided `rx_valid` was clear or is being taken in the same cycle. `per_flag` is left unchanged.
- R4: A character with bad parity sets `per_flag`, does not set `rx_valid`, and still loads its byte into `rx_data`.
- R5: After a character with bad parity, `sc_line_oe` is high for exactly `bit_cycles` consecutive cycles. The pulse starts about one bit time after the parity sample, which puts it inside the guard time that follows the parity bit. `sc_line_oe` stays low after a character with good parity, and it is never high while a character is being sampled.
- R6: If a character with good parity completes while `rx_valid` is high and `rx_ready` is low, `orer_flag` is set and `rx_data` keeps the old byte.
- R7: A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` in the next cycle. If a good character completes in that same cycle, the new byte is loaded, `rx_valid` stays high, and no overrun is flagged.
- R8: `per_flag` and `orer_flag` stay set until a one-cycle pulse on `per_clr` or `orer_clr` clears them.
- R9: `rxi_irq` equals `rie` AND `rx_valid`. `eri_irq` equals `rie` AND (`per_flag` OR `orer_flag`).
- R10: After reset, `rx_valid`, `per_flag`, `orer_flag`, `sc_line_oe` and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_cycles | input | CNT_W | Clocks per bit cell (at least 4) |
| sc_line_i | input | 1 | Level of the shared data line |
| sc_line_oe | output | 1 | High: pull the shared line low (error signal) |
| rie | input | 1 | Receive interrupt enable |
| per_clr | input | 1 | Pulse that clears the parity-error flag |
| orer_clr | input | 1 | Pulse that clears the overrun flag |
| rx_valid | output | 1 | Receive-ready flag: a byte is waiting |
| rx_ready | input | 1 | Consumer accepts the byte (read strobe when rx_valid is high) |
| rx_data | output | DATA_W | Receive data register |
| per_flag | output | 1 | Sticky parity-error flag |
| orer_flag | output | 1 | Sticky overrun flag |
| rxi_irq | output | 1 | Receive interrupt |
| eri_irq | output | 1 | Error interrupt |

## Verification
A consumer read can land in the same clock cycle as the completion of a new good character. The design must then hand over the old byte, load the new one, keep `rx_valid` high and raise no overrun. The bench first measures the cycle count from the start edge to the rise of `rx_valid` on an unread character. It then sends a second character with the first one still pending, and pulses `rx_ready` for exactly the cycle in which that second character completes. The check passes when the old byte is presented during the handshake, `rx_data` afterwards holds the new byte, `rx_valid` is still high and `orer_flag` is clear. A design that handled the read and the completion in separate cycles would report an overrun here instead.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [1:0] {
    SMP_IDLE,
    SMP_START,
    SMP_BITS
  } smp_state_t;

  typedef enum logic [1:0] {
    ERR_IDLE,
    ERR_WAIT,
    ERR_DRIVE
  } err_state_t;

endpackage

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler
  import sc_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic              line_in,
  input  logic              hold_off,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_byte,
  output logic              frame_bad,
  output logic              active
);

  localparam int unsigned IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   line_d;
  smp_state_t             state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [DATA_W-1:0]      shift_q;
  logic                   par_q;
  logic [CNT_W-1:0]       half_m1;
  logic [CNT_W-1:0]       full_m1;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_s  = sync_q[SYNC_STAGES-1];
  assign half_m1 = (bit_cycles >> 1) - CNT_W'(1);
  assign full_m1 = bit_cycles - CNT_W'(1);
  assign active  = (state_q != SMP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d     <= 1'b1;
      state_q    <= SMP_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      par_q      <= 1'b0;
      frame_done <= 1'b0;
      frame_byte <= '0;
      frame_bad  <= 1'b0;
    end else begin
      line_d     <= line_s;
      frame_done <= 1'b0;
      unique case (state_q)
        SMP_IDLE: begin
          if (!hold_off && line_d && !line_s) begin
            state_q <= SMP_START;
            cnt_q   <= '0;
          end
        end
        SMP_START: begin
          if (cnt_q == half_m1) begin
            cnt_q <= '0;
            idx_q <= '0;
            par_q <= 1'b0;
            state_q <= line_s ? SMP_IDLE : SMP_BITS;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SMP_BITS: begin
          if (cnt_q == full_m1) begin
            cnt_q <= '0;
            par_q <= par_q ^ line_s;
            if (idx_q == LAST_IDX) begin
              frame_done <= 1'b1;
              frame_byte <= shift_q;
              frame_bad  <= par_q ^ line_s;
              state_q    <= SMP_IDLE;
            end else begin
              shift_q <= {line_s, shift_q[DATA_W-1:1]};
              idx_q   <= idx_q + IDX_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= SMP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_rx_err_drive.sv
module sc_rx_err_drive
  import sc_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_cycles,
  input  logic             frame_done,
  input  logic             frame_bad,
  output logic             line_oe,
  output logic             busy
);

  err_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_end;

  assign cnt_end = (cnt_q == bit_cycles - CNT_W'(1));
  assign line_oe = (state_q == ERR_DRIVE);
  assign busy    = (state_q != ERR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ERR_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ERR_IDLE: begin
          cnt_q <= '0;
          if (frame_done && frame_bad) state_q <= ERR_WAIT;
        end
        ERR_WAIT: begin
          if (cnt_end) begin
            cnt_q   <= '0;
            state_q <= ERR_DRIVE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ERR_DRIVE: begin
          if (cnt_end) begin
            cnt_q   <= '0;
            state_q <= ERR_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ERR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              frame_bad,
  input  logic              rx_ready,
  input  logic              per_clr,
  input  logic              orer_clr,
  input  logic              rie,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              per_flag,
  output logic              orer_flag,
  output logic              rxi_irq,
  output logic              eri_irq
);

  logic take;
  logic good_done;
  logic room;

  assign take      = rx_valid && rx_ready;
  assign good_done = frame_done && !frame_bad;
  assign room      = !rx_valid || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      per_flag  <= 1'b0;
      orer_flag <= 1'b0;
    end else begin
      if (good_done && room)      rx_valid <= 1'b1;
      else if (take)              rx_valid <= 1'b0;

      if (frame_done && (frame_bad || room)) rx_data <= frame_byte;

      if (frame_done && frame_bad) per_flag <= 1'b1;
      else if (per_clr)            per_flag <= 1'b0;

      if (good_done && !room)      orer_flag <= 1'b1;
      else if (orer_clr)           orer_flag <= 1'b0;
    end
  end

  assign rxi_irq = rie && rx_valid;
  assign eri_irq = rie && (per_flag || orer_flag);

endmodule

// File: rtl/sc_rx_top.sv
module sc_rx_top #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic              sc_line_i,
  output logic              sc_line_oe,
  input  logic              rie,
  input  logic              per_clr,
  input  logic              orer_clr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              per_flag,
  output logic              orer_flag,
  output logic              rxi_irq,
  output logic              eri_irq
);

  logic              frame_done;
  logic [DATA_W-1:0] frame_byte;
  logic              frame_bad;
  logic              smp_active;
  logic              err_busy;

  sc_rx_sampler #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_cycles (bit_cycles),
    .line_in    (sc_line_i),
    .hold_off   (err_busy),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .frame_bad  (frame_bad),
    .active     (smp_active)
  );

  sc_rx_err_drive #(
    .CNT_W (CNT_W)
  ) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_cycles (bit_cycles),
    .frame_done (frame_done),
    .frame_bad  (frame_bad),
    .line_oe    (sc_line_oe),
    .busy       (err_busy)
  );

  sc_rx_status #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .frame_bad  (frame_bad),
    .rx_ready   (rx_ready),
    .per_clr    (per_clr),
    .orer_clr   (orer_clr),
    .rie        (rie),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .per_flag   (per_flag),
    .orer_flag  (orer_flag),
    .rxi_irq    (rxi_irq),
    .eri_irq    (eri_irq)
  );

endmodule

// File: rtl/sc_rx_checker.sv
module sc_rx_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  bit_cycles,
  input logic              sc_line_oe,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              per_flag,
  input logic              orer_flag,
  input logic              frame_done,
  input logic              frame_bad,
  input logic [DATA_W-1:0] frame_byte,
  input logic              smp_active
);

  logic [CNT_W-1:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe_run <= '0;
    else if (sc_line_oe) oe_run <= oe_run + CNT_W'(1);
    else                 oe_run <= '0;
  end

  p_good_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_bad |=> rx_valid);

  p_bad_no_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_bad && !rx_valid |=> !rx_valid);

  p_bad_sets_per_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_bad |=> per_flag);

  p_bad_loads_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_bad |=> rx_data == $past(frame_byte));

  p_err_quiet_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_line_oe |-> !smp_active);

  p_err_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_line_oe |-> oe_run < bit_cycles);

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_bad && rx_valid && !rx_ready
      |=> orer_flag && rx_data == $past(rx_data));

  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !frame_done |=> !rx_valid);

endmodule

bind sc_rx_top sc_rx_checker #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_sc_rx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_cycles (bit_cycles),
  .sc_line_oe (sc_line_oe),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .per_flag   (per_flag),
  .orer_flag  (orer_flag),
  .frame_done (frame_done),
  .frame_bad  (frame_bad),
  .frame_byte (frame_byte),
  .smp_active (smp_active)
);

// File: tb/sc_rx_top_tb.sv
module sc_rx_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bit_cycles = 16'd16;
  logic        tx = 1'b1;
  logic        sc_line_i;
  logic        sc_line_oe;
  logic        rie = 1'b0;
  logic        per_clr = 1'b0;
  logic        orer_clr = 1'b0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        per_flag;
  logic        orer_flag;
  logic        rxi_irq;
  logic        eri_irq;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int err_cnt = 0;
  int t_rise = 0;
  logic v_prev = 1'b0;
  bit  finished = 1'b0;

  logic [7:0] m_rdr = 8'h00;
  logic       m_rdrf = 1'b0;
  logic       m_per = 1'b0;
  logic       m_orer = 1'b0;

  always #5 clk = ~clk;

  assign sc_line_i = tx & ~sc_line_oe;

  sc_rx_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_cycles (bit_cycles),
    .sc_line_i  (sc_line_i),
    .sc_line_oe (sc_line_oe),
    .rie        (rie),
    .per_clr    (per_clr),
    .orer_clr   (orer_clr),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .per_flag   (per_flag),
    .orer_flag  (orer_flag),
    .rxi_irq    (rxi_irq),
    .eri_irq    (eri_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sc_line_oe) err_cnt <= err_cnt + 1;
  end

  always @(negedge clk) begin
    if (rx_valid && !v_prev) t_rise = cyc;
    v_prev = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [7:0] b);
    return ^b;
  endfunction

  task automatic model_frame(input logic [7:0] b, input bit bad);
    if (bad) begin
      m_rdr = b;
      m_per = 1'b1;
    end else if (m_rdrf) begin
      m_orer = 1'b1;
    end else begin
      m_rdr  = b;
      m_rdrf = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    chk(rx_valid == m_rdrf, req, "rx_valid", 32'(rx_valid), 32'(m_rdrf));
    chk(rx_data == m_rdr, req, "rx_data", 32'(rx_data), 32'(m_rdr));
    chk(per_flag == m_per, req, "per_flag", 32'(per_flag), 32'(m_per));
    chk(orer_flag == m_orer, req, "orer_flag", 32'(orer_flag), 32'(m_orer));
    chk(rxi_irq == (rie & m_rdrf), "R9", "rxi_irq", 32'(rxi_irq), 32'(rie & m_rdrf));
    chk(eri_irq == (rie & (m_per | m_orer)), "R9", "eri_irq",
        32'(eri_irq), 32'(rie & (m_per | m_orer)));
  endtask

  // Sends one character; called at a negedge, drives the start bit at once.
  task automatic send_frame(input logic [7:0] b, input bit bad);
    logic [9:0] bits;
    bits = {even_bit(b) ^ bad, b};
    err_cnt = 0;
    tx = 1'b0;
    repeat (bit_cycles) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      tx = bits[i];
      repeat (bit_cycles) @(negedge clk);
    end
    tx = 1'b1;
    repeat (bit_cycles) @(negedge clk);
    chk(sc_line_oe == bad, "R5", "oe mid guard", 32'(sc_line_oe), 32'(bad));
    while (sc_line_oe) @(negedge clk);
    repeat (2 * bit_cycles) @(negedge clk);
    chk(err_cnt == (bad ? int'(bit_cycles) : 0), "R5", "oe length",
        32'(err_cnt), bad ? 32'(bit_cycles) : 32'd0);
  endtask

  task automatic do_read(input string req);
    rx_ready = 1'b1;
    chk(rx_data == m_rdr, req, "data at read", 32'(rx_data), 32'(m_rdr));
    @(negedge clk);
    rx_ready = 1'b0;
    if (m_rdrf) m_rdrf = 1'b0;
    chk(rx_valid == 1'b0, req, "valid after read", 32'(rx_valid), 32'd0);
  endtask

  task automatic pulse_per;
    per_clr = 1'b1;
    @(negedge clk);
    per_clr = 1'b0;
    m_per = 1'b0;
  endtask

  task automatic pulse_orer;
    orer_clr = 1'b1;
    @(negedge clk);
    orer_clr = 1'b0;
    m_orer = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int s_a, s_b, lat;
    void'($urandom(32'h5C7D_0011));
    repeat (4) @(negedge clk);
    rie = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rx_valid == 0, "R10", "rx_valid", 32'(rx_valid), 0);
    chk(per_flag == 0 && orer_flag == 0, "R10", "flags",
        32'({per_flag, orer_flag}), 0);
    chk(sc_line_oe == 0 && rxi_irq == 0 && eri_irq == 0, "R10", "oe/irq",
        32'({sc_line_oe, rxi_irq, eri_irq}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 good character, then read (R7)
    send_frame(8'hA5, 1'b0);
    model_frame(8'hA5, 1'b0);
    check_all("R1");
    do_read("R7");

    // R4 bad parity, then retransmission with good parity (R3 keeps per)
    send_frame(8'h3C, 1'b1);
    model_frame(8'h3C, 1'b1);
    check_all("R4");
    send_frame(8'h3C, 1'b0);
    model_frame(8'h3C, 1'b0);
    check_all("R3");
    pulse_per();
    check_all("R8");
    do_read("R7");

    // R6 overrun under back-pressure
    send_frame(8'h11, 1'b0);
    model_frame(8'h11, 1'b0);
    send_frame(8'h22, 1'b0);
    model_frame(8'h22, 1'b0);
    check_all("R6");
    pulse_orer();
    check_all("R8");
    do_read("R7");

    // R9 interrupts masked
    rie = 1'b0;
    send_frame(8'hC3, 1'b1);
    model_frame(8'hC3, 1'b1);
    check_all("R9");
    rie = 1'b1;
    @(negedge clk);
    check_all("R9");
    pulse_per();

    // R2 short glitch ignored, next character still aligned
    tx = 1'b0;
    repeat (3) @(negedge clk);
    tx = 1'b1;
    err_cnt = 0;
    repeat (12 * bit_cycles) @(negedge clk);
    check_all("R2");
    chk(err_cnt == 0, "R2", "oe after glitch", 32'(err_cnt), 0);
    send_frame(8'h5A, 1'b0);
    model_frame(8'h5A, 1'b0);
    check_all("R2");

    // R7 read and completion in the same cycle
    do_read("R7");
    s_a = cyc;
    send_frame(8'h81, 1'b0);
    model_frame(8'h81, 1'b0);
    lat = t_rise - s_a;
    check_all("R7");
    s_b = cyc;
    fork
      send_frame(8'h7E, 1'b0);
      begin
        while (cyc != s_b + lat - 1) @(negedge clk);
        rx_ready = 1'b1;
        chk(rx_data == 8'h81, "R7", "old byte at read", 32'(rx_data), 32'h81);
        @(negedge clk);
        rx_ready = 1'b0;
      end
    join
    m_rdr = 8'h7E;
    check_all("R7");
    do_read("R7");

    // R1 odd bit time
    bit_cycles = 16'd11;
    send_frame(8'h96, 1'b0);
    model_frame(8'h96, 1'b0);
    check_all("R1");
    send_frame(8'h0F, 1'b1);
    model_frame(8'h0F, 1'b1);
    check_all("R4");
    do_read("R7");
    pulse_per();
    bit_cycles = 16'd16;

    // Random traffic
    for (int n = 0; n < 30; n++) begin
      logic [7:0] b;
      bit bad;
      b   = 8'($urandom);
      bad = ($urandom % 4) == 0;
      send_frame(b, bad);
      model_frame(b, bad);
      check_all(bad ? "R4" : "R3");
      if ($urandom % 2 == 0) do_read("R7");
      if ($urandom % 3 == 0) pulse_per();
      if ($urandom % 3 == 0) pulse_orer();
      if ($urandom % 5 == 0) rie = ~rie;
      @(negedge clk);
      check_all("R8");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule